// File: doc/BRIEF.md
# Prescaled 8-bit PWM generator bank

This block contains one or more pulse-width modulation channels. All channels run from one common clock, and a simple synchronous register port programs them. Each channel has one 32-bit control word. That word holds a clock-divide field, a duty value, a full-on override and an enable.

Inside each channel a prescaler produces a tick once every divide+1 clocks. An 8-bit counter advances on each tick, so one output period is always 256 ticks. The output is high while the counter is below the duty value. The fastest period is therefore 256 clocks.

A write to the control word takes effect in the next cycle, even in the middle of a period. Clearing the enable pulls the output low at once and clears both counters, so the next enable starts a fresh period.

Top module: `pwm_bank`

## Requirements
- R1: After a synchronous active-low reset every control word reads as zero and every output is low.
- R2: The control word has these fields: divide field in bits [12:0], duty in bits [23:16], full-on override in bit 24 and enable in bit 31. A read returns the last written word with bits 30:25 and 15:13 forced to zero.
- R3: With divide field D the counter advances once every D+1 clocks, so each counter value lasts D+1 clocks.
- R4: The output period is 256 counter steps. The output is high while the counter is below the duty value, and a duty of 0 with the override clear keeps the output low.
- R5: With the enable set and bit 24 set, the output stays high and the duty field has no effect.
- R6: A write that clears the enable drives the output low from the next cycle. A later enable restarts with the counter at zero, so the output is high at once when duty is nonzero.
- R7: A write that changes duty while the channel runs takes effect in the next cycle and does not restart or stall the counter.
- R8: Channel n owns address n*16. A write to any other address changes no channel, and a read of any other address returns zero.
- R9: A divide field of 0 advances the counter on every clock, which gives a period of 256 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte address; channel = bits above 4, bits [3:0] must be 0 |
| bus_wdata | input | 32 | Control word to write |
| bus_rdata | output | 32 | Control word at bus_addr, combinational |
| pwm_out | output | NUM_CH | One PWM output per channel, high = active |

## Verification
A write lands in the control register at the clock edge where it is sampled, so its effect on the outputs and on the read data shows up in the same cycle after that edge. The output is a combinational compare of registered state, so it also changes in that cycle. Read data follows the address with no clock.

The bench keeps a reference model of each channel: the elapsed tick count and the last written word. The model is updated on the rising edge, and every output is compared to the model on the falling edge of every cycle. Read-back checks are taken one time step after the address is driven.

// File: rtl/pwm_bank_pkg.sv
// Package: shared field layout and decoded configuration type for the
// PWM bank. Assumes a 32-bit control word per channel.
package pwm_bank_pkg;
    localparam int WORD_W   = 32;
    localparam int DIV_W    = 13;
    localparam int DUTY_W   = 8;
    localparam int DUTY_LSB = 16;
    localparam int FULL_BIT = 24;
    localparam int EN_BIT   = 31;
    localparam int CFG_W    = 2 + DUTY_W + DIV_W;

    // Bits that hold state; every other bit reads back as zero.
    localparam logic [WORD_W-1:0] CFG_MASK =
        (WORD_W'(1) << EN_BIT) | (WORD_W'(1) << FULL_BIT) |
        (((WORD_W'(1) << DUTY_W) - 1) << DUTY_LSB) |
        ((WORD_W'(1) << DIV_W) - 1);

    typedef struct packed {
        logic              en;
        logic              full;
        logic [DUTY_W-1:0] duty;
        logic [DIV_W-1:0]  div;
    } pwm_cfg_t;

    // Decode one stored control word into its fields.
    function automatic pwm_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        pwm_cfg_t c;
        c.en   = w[EN_BIT];
        c.full = w[FULL_BIT];
        c.duty = w[DUTY_LSB +: DUTY_W];
        c.div  = w[DIV_W-1:0];
        return c;
    endfunction
endpackage

// File: rtl/pwm_tick_div.sv
// Prescaler: gives a one-cycle tick every div+1 clocks while run is high.
// Assumes div may change at any time; a >= compare keeps it from running
// past a smaller new limit. Held at zero while run is low.
module pwm_tick_div
    import pwm_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] pre_q;
    logic             at_limit;

    assign at_limit = (pre_q >= div);
    assign tick     = run && at_limit;

    // Count clocks up to the divide limit, then wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_q <= '0;
        end else if (at_limit) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_lane.sv
// Period counter and duty compare for one channel. Assumes tick comes
// from the channel's prescaler. The output is a compare of registered
// state, so it follows a register write in the next cycle.
module pwm_lane
    import pwm_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              full,
    input  logic [DUTY_W-1:0] duty,
    input  logic              tick,
    output logic              out
);
    logic [DUTY_W-1:0] step_q;

    // Advance the period counter on each tick; wraps every 256 ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            step_q <= '0;
        end else if (tick) begin
            step_q <= step_q + 1'b1;
        end
    end

    // High for the first duty steps, or always when the override is set.
    always_comb begin
        out = en && (full || (step_q < duty));
    end
endmodule

// File: rtl/pwm_regfile.sv
// Control word storage for NUM_CH channels. Channel n sits at byte
// address n*16; other offsets are ignored on write and read as zero.
// Reads are combinational from the address.
module pwm_regfile
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output pwm_cfg_t          cfg [NUM_CH]
);
    localparam int SEL_W = ADDR_W - 4;

    logic [SEL_W-1:0]  sel;
    logic [31:0]       sel_ext;
    logic              hit;
    logic [WORD_W-1:0] word_q [NUM_CH];

    assign sel     = bus_addr[ADDR_W-1:4];
    assign sel_ext = 32'(sel);
    assign hit     = (bus_addr[3:0] == 4'd0) && (sel_ext < 32'(NUM_CH));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_word
        // Store the masked word when this channel is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[c] <= '0;
            end else if (bus_wr && hit && (sel_ext == 32'(c))) begin
                word_q[c] <= bus_wdata & CFG_MASK;
            end
        end
        assign cfg[c] = word_to_cfg(word_q[c]);
    end

    // Return the addressed word, zero for unmapped addresses.
    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (hit && (sel_ext == 32'(c))) bus_rdata = word_q[c];
        end
    end
endmodule

// File: rtl/pwm_bank.sv
// Top of the PWM bank: register file plus one prescaler and one lane
// per channel. All channels share clk. Reset is synchronous, active low.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    pwm_cfg_t                  cfg [NUM_CH];
    logic [NUM_CH*CFG_W-1:0]   cfg_flat;
    logic [NUM_CH-1:0]         tick;

    pwm_regfile #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg       (cfg)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign cfg_flat[c*CFG_W +: CFG_W] = cfg[c];

        pwm_tick_div u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (cfg[c].en),
            .div   (cfg[c].div),
            .tick  (tick[c])
        );

        pwm_lane u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (cfg[c].en),
            .full  (cfg[c].full),
            .duty  (cfg[c].duty),
            .tick  (tick[c]),
            .out   (pwm_out[c])
        );
    end
endmodule

// File: rtl/pwm_bank_checker.sv
// Checker for pwm_bank: relates the stored configuration to the outputs
// and the write strobe. Attached with bind below.
module pwm_bank_checker
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr,
    input logic [NUM_CH*CFG_W-1:0] cfg_flat,
    input logic [NUM_CH-1:0]       pwm_out
);
    // R1: the first cycle out of reset shows cleared state and low outputs.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pwm_out == '0) && (cfg_flat == '0));

    // R8: configuration changes only on a write.
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(cfg_flat));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        pwm_cfg_t k;
        assign k = pwm_cfg_t'(cfg_flat[c*CFG_W +: CFG_W]);

        // R6: a disabled channel never drives its output.
        p_disabled_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !k.en |-> !pwm_out[c]);

        // R5: the override holds the output high.
        p_full_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (k.en && k.full) |-> pwm_out[c]);

        // R4: zero duty without the override keeps the output low.
        p_zero_duty_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (k.en && !k.full && (k.duty == '0)) |-> !pwm_out[c]);
    end
endmodule

bind pwm_bank pwm_bank_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .cfg_flat (cfg_flat),
    .pwm_out  (pwm_out)
);

// File: tb/tb_pwm_bank.sv
`timescale 1ns/1ps
module tb_pwm_bank;
    localparam int NCH  = 2;
    localparam int AW   = 8;
    localparam logic [31:0] MASK = 32'h81FF_1FFF;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] pwm_out;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    mon_on   = 1'b0;
    bit    done     = 1'b0;
    string cur_req  = "R4";

    logic [31:0] m_word [NCH];
    int          m_t    [NCH];

    always #5 clk = ~clk;

    pwm_bank #(.NUM_CH(NCH), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    function automatic logic exp_out(logic [31:0] w, int t);
        int d;
        d = int'(w[12:0]) + 1;
        return w[31] && (w[24] || (((t / d) % 256) < int'(w[23:16])));
    endfunction

    // Reference model: last written word and ticks elapsed since enable.
    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
                m_word[c] = '0;
                m_t[c]    = 0;
            end else begin
                if (m_word[c][31]) m_t[c] = m_t[c] + 1;
                else               m_t[c] = 0;
                if (bus_wr && bus_addr == AW'(c * 16))
                    m_word[c] = bus_wdata & MASK;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Output monitor on the falling edge.
    always @(negedge clk) begin
        if (mon_on) begin
            for (int c = 0; c < NCH; c++)
                chk(cur_req, 32'(pwm_out[c]), 32'(exp_out(m_word[c], m_t[c])));
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
        @(negedge clk);
        #2 bus_addr = a;
        #1 chk(req, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", 32'(pwm_out), 32'h0);
        rd_chk("R1", 8'h00, 32'h0);
        rd_chk("R1", 8'h10, 32'h0);
        mon_on = 1'b1;

        // R2: reserved bits read as zero
        cur_req = "R2";
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R2", 8'h00, 32'h81FF_1FFF);
        wr(8'h00, 32'h0000_0000);
        rd_chk("R2", 8'h00, 32'h0);

        // R9: divide 0, duty 64, period of 256 clocks
        cur_req = "R9";
        wr(8'h00, 32'h8040_0000);
        idle(600);

        // R3: divide 2 on channel 1, duty 5
        cur_req = "R3";
        wr(8'h10, 32'h8005_0002);
        idle(900);

        // R5: override with zero duty stays high
        cur_req = "R5";
        wr(8'h00, 32'h8100_0000);
        idle(50);
        chk("R5", 32'(pwm_out[0]), 32'h1);

        // R4: zero duty without override stays low
        cur_req = "R4";
        wr(8'h00, 32'h8000_0000);
        idle(300);
        chk("R4", 32'(pwm_out[0]), 32'h0);

        // R7: change duty on a running channel
        cur_req = "R7";
        wr(8'h10, 32'h80C8_0002);
        idle(700);

        // R6: disable cuts off at once, re-enable restarts high
        cur_req = "R6";
        wr(8'h10, 32'h00C8_0002);
        chk("R6", 32'(pwm_out[1]), 32'h0);
        idle(5);
        wr(8'h10, 32'h80C8_0002);
        chk("R6", 32'(pwm_out[1]), 32'h1);
        idle(100);

        // R8: unmapped addresses change nothing and read zero
        cur_req = "R8";
        wr(8'h20, 32'h8100_0000);
        wr(8'h04, 32'h0000_0000);
        rd_chk("R8", 8'h00, 32'h8000_0000);
        rd_chk("R8", 8'h10, 32'h80C8_0002);
        rd_chk("R8", 8'h20, 32'h0);
        rd_chk("R8", 8'h14, 32'h0);
        idle(20);

        // Random phase: divide changes only through a disabled channel.
        cur_req = "R4";
        for (int i = 0; i < 24; i++) begin
            int          ch;
            logic [31:0] w;
            ch = int'($urandom % NCH);
            w  = {1'b1, 6'($urandom), (($urandom % 8) == 0), 8'($urandom),
                  3'($urandom), 13'($urandom % 4)};
            wr(AW'(ch * 16), w & ~32'h8000_0000);
            wr(AW'(ch * 16), w);
            rd_chk("R2", AW'(ch * 16), w & MASK);
            if (($urandom % 2) == 0) begin
                cur_req = "R7";
                idle(int'($urandom % 300) + 50);
                wr(AW'(ch * 16), {w[31:24], 8'($urandom), w[15:0]});
                cur_req = "R4";
            end
            idle(int'($urandom % 1200) + 200);
        end

        mon_on = 1'b0;
        done   = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule